// File: doc/BRIEF.md
# Pattern-Unlocked Serial Register Port

This block sits beside an asynchronous SRAM-style bus and keeps a small bank of timekeeping registers hidden behind ordinary memory traffic. It oversamples the chip-select, output-enable and write-enable strobes with a fast system clock, and it recognises the end of each read and write cycle. Write cycles carry one key bit each on data line 0. When 64 consecutive key writes match a fixed pattern, the block opens a register window.

While the window is open, the next 64 in-window access cycles move register bits serially over data line 0. Reads shift out a snapshot of the timekeeper image taken when the window opened. Writes assemble bytes, and each byte is committed to the timekeeper only when all eight of its cycles were writes. The memory-inhibit flag stays high for the whole window. After the 64th transfer the port locks again. Cycles whose address lies above the monitored low region are not seen by the port at all.

Top module: `serreg_unlock_port`

## Requirements
- R1: After reset, mem_inhibit, bus_d0_oe, bus_d0_out and tk_byte_wr are 0, and tk_image_out is all zeros.
- R2: 64 in-window write cycles whose data-line-0 values follow the bytes C5h, 3Ah, A3h, 5Ch, C5h, 3Ah, A3h, 5Ch, each byte sent least significant bit first, open the window: mem_inhibit goes to 1.
- R3: After a write bit that differs from the expected key bit, the key position freezes and all further writes are ignored until a read, so even a complete correct key sent afterwards does not open the window.
- R4: An in-window read while the port is locked restarts recognition at key bit 0. Bits sent before the read do not count toward the key, and a full key sent after the read opens the window.
- R5: A cycle whose address has any bit at position 19 or above set is ignored. Such a read neither aborts recognition nor takes part in a transfer, such a write neither advances nor breaks the key, and bus_d0_oe stays 0 during it.
- R6: With the window open, transfer k (k = 0..63) that is an in-window read drives bus_d0_oe high and puts bit k of tk_image_in, as captured when the window opened, on bus_d0_out. Bit k belongs to register k/8, bit k%8.
- R7: Register r is written only when transfers 8r..8r+7 are all writes. tk_image_out[8r+7:8r] then takes the eight written bits, with transfer 8r landing in bit 0, and tk_byte_wr[r] pulses for exactly one clock. A byte with any read among its eight transfers leaves that register unchanged and gives no pulse.
- R8: The 64th transfer closes the window: mem_inhibit returns to 0, and a new key opens the window again without a preceding read.
- R9: While the port is locked, bus_d0_oe stays 0 even during in-window reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Bus chip select, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_addr | input | 21 | Bus address |
| bus_d0_in | input | 1 | Data line 0 as driven by the host |
| tk_image_in | input | 64 | Current timekeeper register image, register 0 in the low byte |
| mem_inhibit | output | 1 | High while the register window is open |
| bus_d0_out | output | 1 | Register bit for the host on data line 0 |
| bus_d0_oe | output | 1 | Output enable for bus_d0_out |
| tk_image_out | output | 64 | Committed register image written by the host |
| tk_byte_wr | output | 8 | One-clock commit strobe per register |

## Verification
Two functions share one event on the last transfer of the window: the commit of register 7 and the relock of the port. The bench ends a write window with eight writes into register 7. It then checks that the register-7 strobe fired once, that the byte landed in the image, and that mem_inhibit has fallen. In the same window a read placed inside register 3 checks that a partly written byte is discarded while its neighbours are still committed.

// File: rtl/pc_pkg.sv
package pc_pkg;

  // One bus cycle, reported on the clock after its terminating strobe edge
  typedef struct packed {
    logic wr;    // an in-window write cycle has just ended
    logic rd;    // an in-window read cycle has just ended
    logic dbit;  // data line 0 as last seen during the write
  } evt_t;

  // Four key bytes, byte 0 in the low bits; the 64-bit key repeats them twice
  localparam logic [31:0] KEY_WORD = 32'h5CA3_3AC5;

  function automatic logic key_bit(input int unsigned idx);
    return KEY_WORD[idx % 32];
  endfunction

endpackage

// File: rtl/pc_strobe_sync.sv
module pc_strobe_sync #(
  parameter int ADDR_W   = 21,
  parameter int WIN_BITS = 19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic                d0,
  input  logic [ADDR_W-1:0]   addr,
  output pc_pkg::evt_t        evt,
  output logic                rd_live
);
  localparam int SW = 4 + ADDR_W;
  localparam logic [SW-1:0] IDLE = {3'b111, 1'b0, {ADDR_W{1'b0}}};

  logic [SW-1:0] m1_q, m2_q;
  logic          wr_q, rd_q, d0_hold_q, win_hold_q;
  logic          d0_hold_d, win_hold_d;
  logic          cs_s, oe_s, we_s, d0_s, wr_act, rd_act, win_now;
  logic [ADDR_W-1:0] addr_s;

  always_comb begin
    cs_s    = m2_q[SW-1];
    oe_s    = m2_q[SW-2];
    we_s    = m2_q[SW-3];
    d0_s    = m2_q[SW-4];
    addr_s  = m2_q[ADDR_W-1:0];
    win_now = (addr_s[ADDR_W-1:WIN_BITS] == '0);
    wr_act  = !cs_s && !we_s;
    rd_act  = !cs_s && !oe_s && we_s;
    d0_hold_d  = wr_act ? d0_s : d0_hold_q;
    win_hold_d = (wr_act || rd_act) ? win_now : win_hold_q;
    evt.wr   = wr_q && !wr_act && win_hold_q;
    evt.rd   = rd_q && !rd_act && win_hold_q;
    evt.dbit = d0_hold_q;
    rd_live  = rd_act && win_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q       <= IDLE;
      m2_q       <= IDLE;
      wr_q       <= 1'b0;
      rd_q       <= 1'b0;
      d0_hold_q  <= 1'b0;
      win_hold_q <= 1'b0;
    end else begin
      m1_q       <= {cs_n, oe_n, we_n, d0, addr};
      m2_q       <= m1_q;
      wr_q       <= wr_act;
      rd_q       <= rd_act;
      d0_hold_q  <= d0_hold_d;
      win_hold_q <= win_hold_d;
    end
  end

  // a cycle ends as a read or as a write, never both at once
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.wr && evt.rd)); // R4

endmodule

// File: rtl/pc_key_match.sv
module pc_key_match #(
  parameter int KEY_BITS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pc_pkg::evt_t  evt,
  input  logic          busy,
  output logic          unlock
);
  localparam int PW = $clog2(KEY_BITS);
  localparam logic [PW-1:0] LAST = PW'(KEY_BITS - 1);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          fail_q, fail_d, hit;

  always_comb begin
    hit    = (evt.dbit == pc_pkg::key_bit(int'(ptr_q)));
    unlock = !busy && evt.wr && !fail_q && hit && (ptr_q == LAST);
    ptr_d  = ptr_q;
    fail_d = fail_q;
    if (busy) begin
      ptr_d  = '0;
      fail_d = 1'b0;
    end else if (evt.rd) begin
      ptr_d  = '0;
      fail_d = 1'b0;
    end else if (evt.wr && !fail_q) begin
      if (hit) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      else     fail_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      fail_q <= fail_d;
    end
  end

  AST_READ_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && evt.rd) |=> (ptr_q == '0 && !fail_q)); // R4

  AST_FAIL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !busy && !evt.rd) |=> $stable(ptr_q)); // R3

endmodule

// File: rtl/pc_xfer_shift.sv
module pc_xfer_shift #(
  parameter int NREG = 8,
  parameter int RW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pc_pkg::evt_t         evt,
  input  logic                 unlock,
  input  logic                 rd_live,
  input  logic [NREG*RW-1:0]   img_in,
  output logic                 busy,
  output logic                 d0_out,
  output logic                 d0_oe,
  output logic [NREG*RW-1:0]   img_out,
  output logic [NREG-1:0]      byte_wr
);
  localparam int NBITS = NREG * RW;
  localparam int CW    = $clog2(NBITS);
  localparam int BW    = $clog2(RW);
  localparam logic [CW-1:0] LAST_ALL  = CW'(NBITS - 1);
  localparam logic [BW-1:0] LAST_BYTE = BW'(RW - 1);

  logic              busy_q, busy_d, allwr_q, allwr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [NBITS-1:0]  snap_q, snap_d, img_q, img_d;
  logic [RW-1:0]     acc_q, acc_d;
  logic [NREG-1:0]   bwr_q, bwr_d;
  logic              step, end_byte, end_all, commit;

  always_comb begin
    step     = busy_q && (evt.wr || evt.rd);
    end_byte = (cnt_q[BW-1:0] == LAST_BYTE);
    end_all  = (cnt_q == LAST_ALL);
    commit   = step && end_byte && allwr_q && evt.wr;
    acc_d    = acc_q;
    if (step && evt.wr) acc_d[cnt_q[BW-1:0]] = evt.dbit;
    allwr_d  = allwr_q;
    if (unlock)    allwr_d = 1'b1;
    else if (step) allwr_d = end_byte ? 1'b1 : (allwr_q && evt.wr);
    bwr_d = '0;
    img_d = img_q;
    if (commit) begin
      bwr_d[cnt_q[CW-1:BW]]        = 1'b1;
      img_d[cnt_q[CW-1:BW]*RW +: RW] = acc_d;
    end
    busy_d = busy_q;
    cnt_d  = cnt_q;
    snap_d = snap_q;
    if (unlock) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      snap_d = img_in;
    end else if (step) begin
      busy_d = !end_all;
      cnt_d  = end_all ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      allwr_q <= 1'b1;
      cnt_q   <= '0;
      snap_q  <= '0;
      img_q   <= '0;
      acc_q   <= '0;
      bwr_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      allwr_q <= allwr_d;
      cnt_q   <= cnt_d;
      snap_q  <= snap_d;
      img_q   <= img_d;
      acc_q   <= acc_d;
      bwr_q   <= bwr_d;
    end
  end

  assign busy    = busy_q;
  assign d0_oe   = busy_q && rd_live;
  assign d0_out  = d0_oe && snap_q[cnt_q];
  assign img_out = img_q;
  assign byte_wr = bwr_q;

  AST_ONE_BYTE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bwr_q)); // R7

  AST_WINDOW_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(unlock)); // R2

  AST_NO_REUNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !unlock); // R2

  AST_LAST_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && end_all) |=> !busy_q); // R8

endmodule

// File: rtl/serreg_unlock_port.sv
module serreg_unlock_port #(
  parameter int ADDR_W   = 21,
  parameter int WIN_BITS = 19,
  parameter int NREG     = 8,
  parameter int RW       = 8,
  parameter int KEY_BITS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cs_n,
  input  logic                 bus_oe_n,
  input  logic                 bus_we_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_d0_in,
  input  logic [NREG*RW-1:0]   tk_image_in,
  output logic                 mem_inhibit,
  output logic                 bus_d0_out,
  output logic                 bus_d0_oe,
  output logic [NREG*RW-1:0]   tk_image_out,
  output logic [NREG-1:0]      tk_byte_wr
);
  pc_pkg::evt_t evt;
  logic         rd_live, unlock, busy;

  pc_strobe_sync #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .oe_n(bus_oe_n),
    .we_n(bus_we_n), .d0(bus_d0_in), .addr(bus_addr),
    .evt(evt), .rd_live(rd_live)
  );

  pc_key_match #(.KEY_BITS(KEY_BITS)) u_key (
    .clk(clk), .rst_n(rst_n), .evt(evt), .busy(busy), .unlock(unlock)
  );

  pc_xfer_shift #(.NREG(NREG), .RW(RW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .evt(evt), .unlock(unlock),
    .rd_live(rd_live), .img_in(tk_image_in), .busy(busy),
    .d0_out(bus_d0_out), .d0_oe(bus_d0_oe), .img_out(tk_image_out),
    .byte_wr(tk_byte_wr)
  );

  assign mem_inhibit = busy;

endmodule

// File: tb/sim_serreg_unlock_port.sv
module sim_serreg_unlock_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, d0 = 1'b0;
  logic [20:0] addr = '0;
  logic [63:0] img_in = 64'hA55A_0FF0_1234_C3E7;
  logic        inhibit, d0_out, d0_oe;
  logic [63:0] img_out;
  logic [7:0]  bwr;
  int          n_chk = 0, n_bad = 0;
  int          bw_cnt [8];
  bit          done = 1'b0;

  localparam logic [7:0] KB [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
  localparam logic [20:0] IN_A  = 21'h00010;
  localparam logic [20:0] OUT_A = 21'h0A_0000;

  always #5 clk = ~clk;

  serreg_unlock_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_oe_n(oe_n),
    .bus_we_n(we_n), .bus_addr(addr), .bus_d0_in(d0), .tk_image_in(img_in),
    .mem_inhibit(inhibit), .bus_d0_out(d0_out), .bus_d0_oe(d0_oe),
    .tk_image_out(img_out), .tk_byte_wr(bwr)
  );

  initial for (int i = 0; i < 8; i++) bw_cnt[i] = 0;
  always @(posedge clk) for (int i = 0; i < 8; i++) if (bwr[i]) bw_cnt[i] = bw_cnt[i] + 1;

  function automatic logic kbit(input int i);
    return KB[(i / 8) % 4][i % 8];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [20:0] a, input logic b);
    addr = a; d0 = b; wait_n(1);
    cs_n = 1'b0; wait_n(3);
    we_n = 1'b0; wait_n(6);
    we_n = 1'b1; wait_n(3);
    cs_n = 1'b1; wait_n(5);
  endtask

  task automatic bus_rd(input logic [20:0] a, output logic got, output logic got_oe);
    addr = a; wait_n(1);
    cs_n = 1'b0; oe_n = 1'b0; wait_n(7);
    got = d0_out; got_oe = d0_oe;
    oe_n = 1'b1; cs_n = 1'b1; wait_n(6);
  endtask

  task automatic send_key(input int from, input int upto);
    for (int i = from; i < upto; i++) bus_wr(IN_A, kbit(i));
  endtask

  task automatic drain_reads();
    logic g, go;
    for (int i = 0; i < 64; i++) bus_rd(IN_A, g, go);
  endtask

  task automatic t_reset();
    chk(!inhibit && !d0_oe && !d0_out, "R1 status", {61'd0, inhibit, d0_oe, d0_out}, 64'd0);
    chk(img_out == '0 && bwr == '0, "R1 image", img_out, 64'd0);
  endtask

  task automatic t_write_window();
    logic g, go;
    logic [63:0] pat = 64'h0123_4567_89AB_CDEF;
    logic [63:0] exp;
    int base [8];
    for (int i = 0; i < 8; i++) base[i] = bw_cnt[i];
    bus_rd(IN_A, g, go);
    chk(go == 1'b0, "R9 locked read oe", {63'd0, go}, 64'd0);
    send_key(0, 64);
    chk(inhibit == 1'b1, "R2 unlocked", {63'd0, inhibit}, 64'd1);
    for (int k = 0; k < 64; k++) begin
      if (k == 28) bus_rd(IN_A, g, go);
      else bus_wr(IN_A, pat[k]);
    end
    exp = pat;
    exp[31:24] = 8'h00;
    chk(img_out == exp, "R7 committed image", img_out, exp);
    for (int r = 0; r < 8; r++)
      chk(bw_cnt[r] - base[r] == ((r == 3) ? 0 : 1), $sformatf("R7 strobe reg%0d", r),
          64'(bw_cnt[r] - base[r]), (r == 3) ? 64'd0 : 64'd1);
    chk(inhibit == 1'b0, "R8 relock with last commit", {63'd0, inhibit}, 64'd0);
  endtask

  task automatic t_read_window();
    logic g, go;
    bus_rd(IN_A, g, go);
    send_key(0, 64);
    chk(inhibit == 1'b1, "R2 unlocked for reads", {63'd0, inhibit}, 64'd1);
    for (int k = 0; k < 64; k++) begin
      bus_rd(IN_A, g, go);
      if (k % 9 == 0 || k == 63) begin
        chk(go == 1'b1, $sformatf("R6 oe bit%0d", k), {63'd0, go}, 64'd1);
        chk(g == img_in[k], $sformatf("R6 data bit%0d", k), {63'd0, g}, {63'd0, img_in[k]});
      end
      if (k == 62) chk(inhibit == 1'b1, "R8 still open at 63", {63'd0, inhibit}, 64'd1);
    end
    chk(inhibit == 1'b0, "R8 closed after 64", {63'd0, inhibit}, 64'd0);
    // relock leaves the pointer at bit 0: a key with no read reopens
    send_key(0, 64);
    chk(inhibit == 1'b1, "R8 reopen without read", {63'd0, inhibit}, 64'd1);
    drain_reads();
    chk(inhibit == 1'b0, "R8 closed again", {63'd0, inhibit}, 64'd0);
  endtask

  task automatic t_mismatch();
    logic g, go;
    bus_rd(IN_A, g, go);
    send_key(0, 10);
    bus_wr(IN_A, ~kbit(10));
    send_key(11, 64);
    chk(inhibit == 1'b0, "R3 mismatch blocks", {63'd0, inhibit}, 64'd0);
    send_key(0, 64);
    chk(inhibit == 1'b0, "R3 frozen until read", {63'd0, inhibit}, 64'd0);
    bus_rd(IN_A, g, go);
    send_key(0, 64);
    chk(inhibit == 1'b1, "R3 read clears freeze", {63'd0, inhibit}, 64'd1);
    drain_reads();
  endtask

  task automatic t_read_abort();
    logic g, go;
    bus_rd(IN_A, g, go);
    send_key(0, 30);
    bus_rd(IN_A, g, go);
    send_key(30, 64);
    chk(inhibit == 1'b0, "R4 read aborts partial key", {63'd0, inhibit}, 64'd0);
    bus_rd(IN_A, g, go);
    send_key(0, 64);
    chk(inhibit == 1'b1, "R4 fresh key after read", {63'd0, inhibit}, 64'd1);
    drain_reads();
  endtask

  task automatic t_out_of_window();
    logic g, go;
    bus_rd(IN_A, g, go);
    for (int i = 0; i < 64; i++) begin
      if (i % 8 == 4) begin
        bus_rd(OUT_A, g, go);
        bus_wr(OUT_A, ~kbit(i));
      end
      bus_wr(IN_A, kbit(i));
    end
    chk(inhibit == 1'b1, "R5 outside cycles ignored in key", {63'd0, inhibit}, 64'd1);
    for (int k = 0; k < 63; k++) bus_rd(IN_A, g, go);
    bus_rd(OUT_A, g, go);
    chk(go == 1'b0, "R5 outside read no oe", {63'd0, go}, 64'd0);
    bus_wr(OUT_A, 1'b1);
    chk(inhibit == 1'b1, "R5 outside cycles not counted", {63'd0, inhibit}, 64'd1);
    bus_rd(IN_A, g, go);
    chk(inhibit == 1'b0, "R5 in-window read ends window", {63'd0, inhibit}, 64'd0);
  endtask

  initial begin
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_write_window();
    t_read_window();
    t_mismatch();
    t_read_abort();
    t_out_of_window();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule